// File: doc/BRIEF.md
# Automatic Gain Ranging Sequencer

This block sequences a two-converter acquisition chain. For every sample the sequencer first asks a fast, low-resolution bipolar converter for a coarse reading of the held signal, taken ahead of the amplifier at unity gain. It turns that reading into the largest power-of-two gain that keeps the amplified signal inside the fine converter's range. It then drives that gain code to a programmable amplifier and starts the high-resolution converter.

When the fine result returns, it is emitted as one 16-bit word together with the gain exponent that was applied to it. Software can therefore rescale every sample exactly.

The coarse and fine stages form a two-stage pipeline. The coarse reading of the next sample may be taken while the fine converter is still busy with the current one. The amplifier setting is held steady for the whole fine conversion. A new gain is only applied once the fine stage is free. A sample request that arrives while the coarse stage is still occupied is dropped and reported.

Top module: `gain_ranging_seq`

## Requirements
- R1: During and right after reset, `crs_start`, `fin_start`, `out_valid` and `overrun` are low, `gain_exp` is 0 (unity gain) and `out_word` is 0.
- R2: A cycle with `sample_en` high while the coarse stage is idle makes `crs_start` high for exactly one cycle, in the next cycle.
- R3: The coarse code is 10-bit two's complement. The gain exponent is 8 minus the bit position of the highest set bit of its magnitude, limited to the range 0..8. A magnitude of zero gives 8, and the code -512 (magnitude 512) gives 0.
- R4: `gain_exp` takes a new coarse decision only while the fine stage is idle, one cycle after that decision is latched. `fin_start` pulses for one cycle in the cycle after `gain_exp` changes. `gain_exp` stays constant from that point until the fine result has been accepted.
- R5: A `fin_done` pulse while a fine conversion is in progress makes `out_valid` high for one cycle in the next cycle. In that cycle `out_word[11:0]` holds `fin_code` and `out_word[15:12]` holds the gain exponent used for that sample.
- R6: The exponent packed with each fine result is the one applied to that sample, even when the next sample's coarse decision is already waiting.
- R7: Once its result has been handed to the fine stage, the coarse stage accepts a new `sample_en` while the fine conversion is still running.
- R8: `sample_en` arriving while the coarse stage is converting or holding an unhanded result is dropped. In that case no `crs_start` is issued and `overrun` is high for one cycle, in the next cycle.
- R9: `crs_done` outside a coarse conversion and `fin_done` outside a fine conversion are ignored. They produce no output strobe and no change of `gain_exp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample clock enable, requests a new coarse conversion |
| crs_start | output | 1 | One-cycle start pulse to the coarse converter |
| crs_done | input | 1 | Coarse conversion complete |
| crs_code | input | 10 | Coarse result, two's complement |
| gain_exp | output | 4 | Amplifier gain exponent, gain = 2^gain_exp |
| fin_start | output | 1 | One-cycle start pulse to the fine converter |
| fin_done | input | 1 | Fine conversion complete |
| fin_code | input | 12 | Fine result |
| out_valid | output | 1 | Paired result strobe |
| out_word | output | 16 | {gain exponent, fine result} |
| overrun | output | 1 | One-cycle pulse when a sample request is dropped |

## Verification
Every input is applied on a falling edge, so each result has a fixed due cycle. `crs_start`, `overrun` and `out_valid` are due at the first falling edge after the causing input. A new `gain_exp` is due two falling edges after `crs_done` when the fine stage is idle, and `fin_start` is due one falling edge after that.

The bench samples each output at exactly that edge and checks again one edge later that the pulse has ended. Gain stability and the gain-to-sample pairing are checked on every falling edge of a fine conversion that overlaps a waiting coarse decision.

// File: rtl/gr_pkg.sv
package gr_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WAIT = 2'd1,
    CS_HOLD = 2'd2
  } coarse_st_e;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_SETTLE = 2'd1,
    FS_BUSY   = 2'd2
  } fine_st_e;

endpackage

// File: rtl/gr_gain_enc.sv
module gr_gain_enc #(
  parameter int CRS_W   = 10,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 8
) (
  input  logic [CRS_W-1:0] code,
  output logic [EXP_W-1:0] exp_o
);

  logic [CRS_W-1:0] mag;
  int               top_pos;
  logic             any_set;

  // magnitude of a two's complement code; the most negative value maps to 2^(CRS_W-1)
  always_comb begin
    mag = code[CRS_W-1] ? (~code + CRS_W'(1)) : code;
  end

  // position of the highest set bit in the magnitude
  always_comb begin
    top_pos = 0;
    any_set = 1'b0;
    for (int i = 0; i < CRS_W; i++) begin
      if (mag[i]) begin
        top_pos = i;
        any_set = 1'b1;
      end
    end
  end

  // larger magnitude means less gain; clamp to the available range
  always_comb begin
    if (!any_set) begin
      exp_o = EXP_W'(MAX_EXP);
    end else if (top_pos >= MAX_EXP) begin
      exp_o = '0;
    end else begin
      exp_o = EXP_W'(MAX_EXP - top_pos);
    end
  end

  // R3
  always_comb begin
    gain_range_chk : assert (int'(exp_o) <= MAX_EXP);
  end

endmodule

// File: rtl/gr_coarse_stage.sv
module gr_coarse_stage
  import gr_pkg::*;
#(
  parameter int CRS_W   = 10,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             crs_done,
  input  logic [CRS_W-1:0] crs_code,
  input  logic             take,
  output logic             crs_start,
  output logic             overrun,
  output logic             pend_valid,
  output logic [EXP_W-1:0] pend_exp
);

  coarse_st_e       st_q, st_d;
  logic             start_d, ovr_d, exp_en;
  logic [EXP_W-1:0] enc_exp;
  logic [EXP_W-1:0] exp_q;

  gr_gain_enc #(
    .CRS_W  (CRS_W),
    .EXP_W  (EXP_W),
    .MAX_EXP(MAX_EXP)
  ) u_enc (
    .code (crs_code),
    .exp_o(enc_exp)
  );

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    ovr_d   = 1'b0;
    exp_en  = 1'b0;
    case (st_q)
      CS_IDLE: begin
        if (sample_en) begin
          start_d = 1'b1;
          st_d    = CS_WAIT;
        end
      end
      CS_WAIT: begin
        ovr_d = sample_en;
        if (crs_done) begin
          exp_en = 1'b1;
          st_d   = CS_HOLD;
        end
      end
      CS_HOLD: begin
        ovr_d = sample_en;
        if (take) begin
          st_d = CS_IDLE;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CS_IDLE;
      crs_start <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      st_q      <= st_d;
      crs_start <= start_d;
      overrun   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
    end else if (exp_en) begin
      exp_q <= enc_exp;
    end
  end

  assign pend_valid = (st_q == CS_HOLD);
  assign pend_exp   = exp_q;

  // R2
  crs_start_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
    crs_start |=> !crs_start);

  // R8
  overrun_excl_chk : assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !crs_start);

  // R9
  stray_crs_done_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_IDLE) && crs_done && !sample_en |=> !pend_valid);

endmodule

// File: rtl/gr_fine_stage.sv
module gr_fine_stage
  import gr_pkg::*;
#(
  parameter int FIN_W = 12,
  parameter int EXP_W = 4,
  localparam int OUT_W = FIN_W + EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_valid,
  input  logic [EXP_W-1:0] pend_exp,
  input  logic             fin_done,
  input  logic [FIN_W-1:0] fin_code,
  output logic             take,
  output logic [EXP_W-1:0] gain_exp,
  output logic             fin_start,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);

  fine_st_e st_q, st_d;
  logic     start_d, valid_d, gain_en, word_en;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    valid_d = 1'b0;
    gain_en = 1'b0;
    word_en = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (pend_valid) begin
          gain_en = 1'b1;
          st_d    = FS_SETTLE;
        end
      end
      FS_SETTLE: begin
        start_d = 1'b1;
        st_d    = FS_BUSY;
      end
      FS_BUSY: begin
        if (fin_done) begin
          valid_d = 1'b1;
          word_en = 1'b1;
          st_d    = FS_IDLE;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  assign take = gain_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FS_IDLE;
      fin_start <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      fin_start <= start_d;
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_exp <= '0;
    end else if (gain_en) begin
      gain_exp <= pend_exp;
    end
  end

  // the amplifier setting is still the one this sample was converted at
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word <= '0;
    end else if (word_en) begin
      out_word <= {gain_exp, fin_code};
    end
  end

  // R4
  gain_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FS_IDLE) |=> $stable(gain_exp));

  // R4
  fin_start_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
    fin_start |=> !fin_start);

  // R5
  out_valid_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  stray_fin_done_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FS_BUSY) && fin_done |=> !out_valid);

endmodule

// File: rtl/gain_ranging_seq.sv
module gain_ranging_seq #(
  parameter int CRS_W   = 10,
  parameter int FIN_W   = 12,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 8,
  localparam int OUT_W  = FIN_W + EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  output logic             crs_start,
  input  logic             crs_done,
  input  logic [CRS_W-1:0] crs_code,
  output logic [EXP_W-1:0] gain_exp,
  output logic             fin_start,
  input  logic             fin_done,
  input  logic [FIN_W-1:0] fin_code,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word,
  output logic             overrun
);

  logic             pend_valid;
  logic [EXP_W-1:0] pend_exp;
  logic             take;

  gr_coarse_stage #(
    .CRS_W  (CRS_W),
    .EXP_W  (EXP_W),
    .MAX_EXP(MAX_EXP)
  ) u_coarse (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .crs_done  (crs_done),
    .crs_code  (crs_code),
    .take      (take),
    .crs_start (crs_start),
    .overrun   (overrun),
    .pend_valid(pend_valid),
    .pend_exp  (pend_exp)
  );

  gr_fine_stage #(
    .FIN_W(FIN_W),
    .EXP_W(EXP_W)
  ) u_fine (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_valid(pend_valid),
    .pend_exp  (pend_exp),
    .fin_done  (fin_done),
    .fin_code  (fin_code),
    .take      (take),
    .gain_exp  (gain_exp),
    .fin_start (fin_start),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  // R1
  reset_quiet_chk : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !crs_start && !fin_start && !out_valid && !overrun);

endmodule

// File: tb/gain_ranging_seq_test.sv
module gain_ranging_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic        crs_done = 1'b0;
  logic [9:0]  crs_code = '0;
  logic        fin_done = 1'b0;
  logic [11:0] fin_code = '0;
  logic        crs_start, fin_start, out_valid, overrun;
  logic [3:0]  gain_exp;
  logic [15:0] out_word;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  gain_ranging_seq uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .crs_start(crs_start),
    .crs_done(crs_done), .crs_code(crs_code), .gain_exp(gain_exp),
    .fin_start(fin_start), .fin_done(fin_done), .fin_code(fin_code),
    .out_valid(out_valid), .out_word(out_word), .overrun(overrun)
  );

  // {coarse code, fine code, expected exponent}
  localparam int NV = 17;
  localparam logic [25:0] VEC [NV] = '{
    {10'h000, 12'h0A5, 4'd8},
    {10'h001, 12'h111, 4'd8},
    {10'h002, 12'h222, 4'd7},
    {10'h003, 12'h333, 4'd7},
    {10'h3FF, 12'h444, 4'd8},
    {10'h3FE, 12'h555, 4'd7},
    {10'h064, 12'h666, 4'd2},
    {10'h0FF, 12'h777, 4'd1},
    {10'h100, 12'h888, 4'd0},
    {10'h1FF, 12'h999, 4'd0},
    {10'h200, 12'hAAA, 4'd0},
    {10'h300, 12'hBBB, 4'd0},
    {10'h301, 12'hCCC, 4'd1},
    {10'h37F, 12'hDDD, 4'd1},
    {10'h380, 12'hEEE, 4'd1},
    {10'h381, 12'hFFF, 4'd2},
    {10'h010, 12'h5A5, 4'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic start_coarse();
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    check(crs_start == 1'b1, "R2 start pulse", int'(crs_start), 1);
    @(negedge clk);
    check(crs_start == 1'b0, "R2 start ends", int'(crs_start), 0);
  endtask

  task automatic give_coarse(input logic [9:0] code);
    @(negedge clk) begin crs_code = code; crs_done = 1'b1; end
    @(negedge clk) crs_done = 1'b0;
  endtask

  // fine stage idle: gain due next edge, fin_start the one after
  task automatic expect_handoff(input logic [3:0] e);
    @(negedge clk);
    check(gain_exp == e, "R3 gain exponent", int'(gain_exp), int'(e));
    @(negedge clk);
    check(fin_start == 1'b1, "R4 fine start", int'(fin_start), 1);
  endtask

  task automatic give_fine(input logic [11:0] code, input logic [3:0] e, input string req);
    @(negedge clk) begin fin_code = code; fin_done = 1'b1; end
    @(negedge clk) fin_done = 1'b0;
    check(out_valid == 1'b1, "R5 out strobe", int'(out_valid), 1);
    check(out_word == {e, code}, req, int'(out_word), int'({e, code}));
    @(negedge clk);
    check(out_valid == 1'b0, "R5 strobe ends", int'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs in reset and after release
    check(!crs_start && !fin_start && !out_valid && !overrun, "R1 strobes in reset",
          int'({crs_start, fin_start, out_valid, overrun}), 0);
    check(gain_exp == 4'd0 && out_word == 16'd0, "R1 values in reset",
          int'({gain_exp, out_word}), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(!crs_start && !fin_start && !out_valid && !overrun && gain_exp == 4'd0,
          "R1 after release", int'({crs_start, fin_start, out_valid, overrun, gain_exp}), 0);

    for (int i = 0; i < NV; i++) begin
      start_coarse();
      repeat (2) @(negedge clk);
      give_coarse(VEC[i][25:16]);
      expect_handoff(VEC[i][3:0]);
      repeat (3) @(negedge clk);
      give_fine(VEC[i][15:4], VEC[i][3:0], "R5 packed word");
    end

    // R9 stray done strobes while idle; last gain exponent is 4
    @(negedge clk) begin crs_code = 10'h000; crs_done = 1'b1; fin_done = 1'b1; end
    @(negedge clk) begin crs_done = 1'b0; fin_done = 1'b0; end
    for (int k = 0; k < 4; k++) begin
      check(!out_valid && !fin_start, "R9 no strobe", int'({out_valid, fin_start}), 0);
      check(gain_exp == 4'd4, "R9 gain kept", int'(gain_exp), 4);
      @(negedge clk);
    end

    // R8 request while coarse converting
    start_coarse();
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    check(overrun == 1'b1, "R8 overrun flagged", int'(overrun), 1);
    check(crs_start == 1'b0, "R8 no restart", int'(crs_start), 0);
    @(negedge clk);
    check(overrun == 1'b0, "R8 overrun ends", int'(overrun), 0);
    give_coarse(10'h020);
    expect_handoff(4'd3);
    repeat (2) @(negedge clk);
    give_fine(12'h321, 4'd3, "R8 surviving sample");
    repeat (3) begin
      check(!crs_start && !fin_start, "R8 dropped stays dropped",
            int'({crs_start, fin_start}), 0);
      @(negedge clk);
    end

    // R6 R7 overlap: sample A exp 7, sample B exp 1
    start_coarse();
    give_coarse(10'h003);
    expect_handoff(4'd7);
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    check(crs_start == 1'b1, "R7 coarse during fine", int'(crs_start), 1);
    give_coarse(10'h380);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(gain_exp == 4'd7, "R4 gain held in conversion", int'(gain_exp), 7);
    end
    @(negedge clk) begin fin_code = 12'h123; fin_done = 1'b1; end
    @(negedge clk) fin_done = 1'b0;
    check(out_valid && out_word == {4'd7, 12'h123}, "R6 tag of first sample",
          int'(out_word), int'({4'd7, 12'h123}));
    @(negedge clk);
    check(gain_exp == 4'd1, "R4 next gain applied", int'(gain_exp), 1);
    @(negedge clk);
    check(fin_start == 1'b1, "R4 next fine start", int'(fin_start), 1);
    repeat (2) @(negedge clk);
    give_fine(12'hABC, 4'd1, "R6 tag of second sample");

    summary();
    $finish;
  end

endmodule